// File: doc/BRIEF.md
# Half-Duplex Collision Detect Logic

This block decides when a 10/100 twisted-pair transceiver reports a collision to its MAC. It looks at transmit activity and receive activity, which other parts of the transceiver supply, and raises the collision output when both are active while the port runs half duplex. Full duplex, a failed link and the diagnostic loopback mode each switch collision detection off. At 10 Mbps, an SQE test pulse or a jabber condition also raises collision, and the receive data nibble is forced to zero while the collision lasts.

The block also supplies the collision part of carrier sense. Once a real collision starts, carrier sense is held until both the transmit packet and the receive packet have ended. It also drives a disable for the internal carrier-sense loopback path. A test control turns the transmit enable from the MAC straight into the collision output, overriding the gating, and turns off the line drivers. Every output is registered, so each output follows its inputs one clock later.

Top module: `hdcol_top`

## Requirements
- R1: When `tx_act` and `rx_act` are both high in half duplex (`full_dup`=0, `link_fail`=0, `diag_lpbk`=0, `col_test`=0), `col` is high one clock later. Outside test mode it is low one clock after a cycle with no qualifying cause.
- R2: When any of `full_dup`, `link_fail` or `diag_lpbk` is high and `col_test` is low, `col` is low one clock later, whatever the activity, SQE or jabber inputs are.
- R3: `crs_lpbk_dis` is high in exactly those cycles in which `col` or `crs_col` is high.
- R4: `crs_col` rises one clock after a half-duplex overlap of transmit and receive. It stays high while either `tx_act` or `rx_act` is high and falls one clock after a cycle in which both are low, or in which gating or test mode is active.
- R5: `rxd_zero` is high one clock after a cycle with a collision cause (overlap, SQE or jabber) in 10 Mbps mode (`spd100`=0), gating inactive and `col_test` low. It is never high one clock after a cycle with `spd100`=1.
- R6: At 10 Mbps with gating inactive, a high `sqe_test` or a high `jabber` raises `col` one clock later. At 100 Mbps (`spd100`=1) neither of them has any effect on `col`.
- R7: When `col_test` is high, `col` equals the `tx_en` of the previous cycle regardless of the gating inputs, and `tp_out_dis` is high one clock after each cycle in which `col_test` is high and low otherwise.
- R8: While `rst_n` is low at a clock edge, every output is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_act | input | 1 | Transmit packet in progress on the line |
| rx_act | input | 1 | Receive activity detected on the line |
| full_dup | input | 1 | 1 = full duplex |
| link_fail | input | 1 | 1 = link is in the fail state |
| diag_lpbk | input | 1 | 1 = diagnostic loopback mode |
| spd100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| sqe_test | input | 1 | SQE test pulse in progress |
| jabber | input | 1 | Jabber condition detected |
| col_test | input | 1 | Collision test control bit |
| tx_en | input | 1 | Transmit enable from the MAC |
| col | output | 1 | Collision indication to the MAC |
| crs_col | output | 1 | Carrier sense contribution held from a collision |
| crs_lpbk_dis | output | 1 | Disable for internal carrier-sense loopback |
| tp_out_dis | output | 1 | Disable for the twisted-pair line drivers |
| rxd_zero | output | 1 | Force the receive data nibble to zero |

## Verification
On every cycle, the assertions check the gating of collision by duplex mode, that `rxd_zero` stays quiet at 100 Mbps, that held carrier falls after both directions go idle, the loopback-disable relation and the echo of transmit enable in test mode. Only the bench scenarios show the full stretch of carrier sense across a tail of receive-only activity, the SQE and jabber causes being ignored at 100 Mbps, and the reset state. Test mode overriding each gating input only shows up under mixed random stimulus.

// File: rtl/hdcol_pkg.sv
// Shared types for the half-duplex collision logic.
package hdcol_pkg;

    // Qualified collision causes for one cycle.
    typedef struct packed {
        logic gate_ok;   // half duplex, link up, no diagnostic loopback
        logic overlap;   // transmit and receive both active
        logic aux10;     // 10 Mbps SQE test or jabber
    } col_cause_t;

endpackage

// File: rtl/hdcol_qualify.sv
// hdcol_qualify: combinational decision of the next collision state.
// Assumes all inputs are synchronous to the block clock. With
// TEST_OVERRIDES_GATE = 1 the test bit ignores the gating inputs.
module hdcol_qualify
    import hdcol_pkg::*;
#(
    parameter bit TEST_OVERRIDES_GATE = 1'b1
) (
    input  logic       tx_act,
    input  logic       rx_act,
    input  logic       full_dup,
    input  logic       link_fail,
    input  logic       diag_lpbk,
    input  logic       spd100,
    input  logic       sqe_test,
    input  logic       jabber,
    input  logic       col_test,
    input  logic       tx_en,
    output col_cause_t cause,
    output logic       col_next,
    output logic       zero_next,
    output logic       hold_seed
);

    logic normal_col;

    // Collect the qualified causes.
    always_comb begin
        cause.gate_ok = !full_dup && !link_fail && !diag_lpbk;
        cause.overlap = tx_act && rx_act;
        cause.aux10   = !spd100 && (sqe_test || jabber);
    end

    // Collision from line activity outside test mode.
    always_comb begin
        normal_col = cause.gate_ok && (cause.overlap || cause.aux10);
    end

    // Test mode source selection; the variant is picked by parameter.
    generate
        if (TEST_OVERRIDES_GATE) begin : g_test_free
            always_comb col_next = col_test ? tx_en : normal_col;
        end else begin : g_test_gated
            always_comb col_next = col_test ? (tx_en && cause.gate_ok) : normal_col;
        end
    endgenerate

    // Receive nibble zeroing applies only to a real 10 Mbps collision.
    always_comb begin
        zero_next = !spd100 && !col_test && normal_col;
    end

    // Seed of the carrier hold: a genuine half-duplex overlap.
    always_comb begin
        hold_seed = !col_test && cause.gate_ok && cause.overlap;
    end

endmodule

// File: rtl/hdcol_carrier_hold.sv
// hdcol_carrier_hold: keeps carrier sense up from the start of a
// collision until both directions are idle. Assumes tx_act and rx_act
// fall at packet end. Gating or test mode clears the hold.
module hdcol_carrier_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_seed,
    input  logic any_act,
    input  logic keep_ok,
    output logic hold_q
);

    // Set on a collision, keep while any packet is active.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= keep_ok && any_act && (hold_q || hold_seed);
    end

    // R4: after a cycle with both directions idle the hold is gone.
    a_r4_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !any_act) |=> !hold_q);

endmodule

// File: rtl/hdcol_outreg.sv
// hdcol_outreg: output register stage. Assumes the next-state values
// are settled one setup time before the clock edge.
module hdcol_outreg (
    input  logic clk,
    input  logic rst_n,
    input  logic col_next,
    input  logic zero_next,
    input  logic test_next,
    output logic col_q,
    output logic zero_q,
    output logic tp_dis_q
);

    // Register the collision, nibble zero and driver disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q    <= 1'b0;
            zero_q   <= 1'b0;
            tp_dis_q <= 1'b0;
        end else begin
            col_q    <= col_next;
            zero_q   <= zero_next;
            tp_dis_q <= test_next;
        end
    end

    // R5: nibble zeroing only ever accompanies a collision.
    a_r5_zero_with_col: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q |-> col_q);

endmodule

// File: rtl/hdcol_top.sv
// hdcol_top: half-duplex collision detect for a 10/100 transceiver.
// Assumes activity, SQE and jabber come from line logic in this
// clock domain. All outputs are registered (one clock latency).
module hdcol_top
    import hdcol_pkg::*;
#(
    parameter bit TEST_OVERRIDES_GATE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_act,
    input  logic rx_act,
    input  logic full_dup,
    input  logic link_fail,
    input  logic diag_lpbk,
    input  logic spd100,
    input  logic sqe_test,
    input  logic jabber,
    input  logic col_test,
    input  logic tx_en,
    output logic col,
    output logic crs_col,
    output logic crs_lpbk_dis,
    output logic tp_out_dis,
    output logic rxd_zero
);

    col_cause_t cause;
    logic       col_next;
    logic       zero_next;
    logic       hold_seed;
    logic       hold_q;
    logic       keep_ok;
    logic       any_act;

    hdcol_qualify #(
        .TEST_OVERRIDES_GATE(TEST_OVERRIDES_GATE)
    ) u_qualify (
        .tx_act    (tx_act),
        .rx_act    (rx_act),
        .full_dup  (full_dup),
        .link_fail (link_fail),
        .diag_lpbk (diag_lpbk),
        .spd100    (spd100),
        .sqe_test  (sqe_test),
        .jabber    (jabber),
        .col_test  (col_test),
        .tx_en     (tx_en),
        .cause     (cause),
        .col_next  (col_next),
        .zero_next (zero_next),
        .hold_seed (hold_seed)
    );

    // Conditions that let the carrier hold survive a cycle.
    always_comb begin
        keep_ok = cause.gate_ok && !col_test;
        any_act = tx_act || rx_act;
    end

    hdcol_carrier_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_seed (hold_seed),
        .any_act   (any_act),
        .keep_ok   (keep_ok),
        .hold_q    (hold_q)
    );

    hdcol_outreg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_next  (col_next),
        .zero_next (zero_next),
        .test_next (col_test),
        .col_q     (col),
        .zero_q    (rxd_zero),
        .tp_dis_q  (tp_out_dis)
    );

    // Drive the carrier outputs from the registered state.
    always_comb begin
        crs_col      = hold_q;
        crs_lpbk_dis = col || hold_q;
    end

    // R2: full duplex outside test mode leaves no collision.
    a_r2_fdx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(full_dup && !col_test) |-> !col);

    // R5: nothing is zeroed after a 100 Mbps cycle.
    a_r5_fast_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spd100) |-> !rxd_zero);

    // R3: held carrier always disables the loopback path.
    a_r3_hold_blocks_lpbk: assert property (@(posedge clk) disable iff (!rst_n)
        crs_col |-> crs_lpbk_dis);

    // R7: with drivers off for test, collision echoes last tx_en.
    a_r7_test_echo: assert property (@(posedge clk) disable iff (!rst_n)
        tp_out_dis |-> (col == $past(tx_en)));

    // R1: a half-duplex overlap outside test mode gives a collision.
    a_r1_overlap_col: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_act && rx_act && !full_dup && !link_fail && !diag_lpbk && !col_test) |=> col);

endmodule

// File: tb/hdcol_top_tb.sv
// Bench for hdcol_top: directed corners plus seeded random stimulus.
module hdcol_top_tb;

    logic clk = 1'b0;
    logic rst_n, tx_act, rx_act, full_dup, link_fail, diag_lpbk, spd100;
    logic sqe_test, jabber, col_test, tx_en;
    logic col, crs_col, crs_lpbk_dis, tp_out_dis, rxd_zero;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // Expected register state of the model.
    bit e_col, e_hold, e_zero, e_tp;
    string col_tag;

    always #2 clk = ~clk;

    hdcol_top u_dut (
        .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
        .full_dup(full_dup), .link_fail(link_fail), .diag_lpbk(diag_lpbk),
        .spd100(spd100), .sqe_test(sqe_test), .jabber(jabber),
        .col_test(col_test), .tx_en(tx_en), .col(col), .crs_col(crs_col),
        .crs_lpbk_dis(crs_lpbk_dis), .tp_out_dis(tp_out_dis), .rxd_zero(rxd_zero)
    );

    function automatic bit f_gate(bit fd, bit lf, bit dl);
        return !fd && !lf && !dl;
    endfunction

    function automatic bit f_col(bit t, bit r, bit fd, bit lf, bit dl,
                                 bit s100, bit sq, bit jb, bit ct, bit te);
        if (ct) return te;
        return f_gate(fd, lf, dl) && ((t && r) || (!s100 && (sq || jb)));
    endfunction

    task automatic check(string tag, bit act, bit exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Compare every output against the model after an edge.
    task automatic check_all();
        check(col_tag, col, e_col, "col");
        check("R4", crs_col, e_hold, "crs_col");
        check("R3", crs_lpbk_dis, e_col || e_hold, "crs_lpbk_dis");
        check("R7", tp_out_dis, e_tp, "tp_out_dis");
        check("R5", rxd_zero, e_zero, "rxd_zero");
    endtask

    // Compute the expected state the next edge will load.
    task automatic predict();
        bit g;
        g = f_gate(full_dup, link_fail, diag_lpbk);
        e_col  = f_col(tx_act, rx_act, full_dup, link_fail, diag_lpbk,
                       spd100, sqe_test, jabber, col_test, tx_en);
        e_zero = !spd100 && !col_test && g && ((tx_act && rx_act) || sqe_test || jabber);
        e_tp   = col_test;
        e_hold = g && !col_test && (tx_act || rx_act) && (e_hold || (tx_act && rx_act));
        if (col_test)                      col_tag = "R7";
        else if (!g)                       col_tag = "R2";
        else if (tx_act && rx_act)         col_tag = "R1";
        else if (!spd100 || sqe_test || jabber) col_tag = "R6";
        else                               col_tag = "R1";
    endtask

    // Apply one input vector at the falling edge and check after it.
    task automatic step(bit t, bit r, bit fd, bit lf, bit dl, bit s100,
                        bit sq, bit jb, bit ct, bit te);
        tx_act = t; rx_act = r; full_dup = fd; link_fail = lf; diag_lpbk = dl;
        spd100 = s100; sqe_test = sq; jabber = jb; col_test = ct; tx_en = te;
        predict();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        rst_n = 1'b0;
        tx_act = 0; rx_act = 1; full_dup = 0; link_fail = 0; diag_lpbk = 0;
        spd100 = 0; sqe_test = 1; jabber = 1; col_test = 1; tx_en = 1;
        repeat (3) @(negedge clk);
        // R8: reset state with every cause present at the inputs.
        check("R8", col, 1'b0, "col");
        check("R8", crs_col, 1'b0, "crs_col");
        check("R8", crs_lpbk_dis, 1'b0, "crs_lpbk_dis");
        check("R8", tp_out_dis, 1'b0, "tp_out_dis");
        check("R8", rxd_zero, 1'b0, "rxd_zero");
        rst_n = 1'b1;
        e_hold = 1'b0;

        // R1, R4: overlap, then a receive-only tail keeps carrier.
        step(1, 1, 0, 0, 0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R4", crs_col, 1'b1, "crs_col held by rx tail");
        step(0, 1, 0, 0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R4", crs_col, 1'b0, "crs_col after both idle");
        // R6: SQE and jabber at 100 Mbps are ignored, at 10 Mbps they collide.
        step(0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
        check("R6", col, 1'b0, "col sqe/jabber at 100");
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        check("R6", col, 1'b1, "col sqe at 10");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R5", rxd_zero, 1'b1, "rxd_zero jabber at 10");
        // R2: each gating input suppresses an overlap.
        step(1, 1, 1, 0, 0, 0, 1, 1, 0, 0);
        step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 1, 0, 0, 0, 0, 0);
        check("R2", col, 1'b0, "col in loopback");
        // R7: test mode overrides gating.
        step(0, 0, 1, 1, 1, 1, 0, 0, 1, 1);
        check("R7", col, 1'b1, "col echo tx_en");
        step(0, 0, 1, 0, 0, 1, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

        // Seeded random mix.
        void'($urandom(32'd1207));
        for (int i = 0; i < 4000; i++) begin
            bit blk;
            blk = ($urandom % 8) == 0;
            step($urandom % 2, $urandom % 2, blk && ($urandom % 2),
                 blk && ($urandom % 2), blk && ($urandom % 2), $urandom % 2,
                 ($urandom % 6) == 0, ($urandom % 8) == 0,
                 ($urandom % 10) == 0, $urandom % 2);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule